// File: doc/BRIEF.md
# Nibble-Coded Register Access Slave

This block is the device side of a narrow host link. The host owns an 8-bit data bus and puts one command byte on it per strobe. The block holds a small register file and reads out a 4-bit lane on a status byte. Each byte has three parts. The top three bits are an opcode. Bit 4 picks the upper or lower half of the addressed register. The low four bits are an offset or a data nibble, depending on the phase of the transaction.

A write has three steps. The host opens it with a write-address byte, sends any number of repeated address or staging bytes, and then sends one data byte whose opcode bits are all zero. That data byte commits its nibble into the chosen half of the register. A read has two steps. The host opens it with a read-address byte, and the selected nibble then appears on status bits 6:3 until an end byte closes the transaction.

Offset 10 is an interrupt status register. Three event inputs set its bits, and writing a 1 to a bit clears it. Offset 11 holds the mask that drives the interrupt output. The upper nibbles of offsets 12 and 13 drive the unit enables and the address-accept mode. A key value in the lower nibble of offset 13 switches offsets 6 and 7 over to a second pair of storage registers.

Top module: `nib_reg_slave`

## Requirements
- R1: After reset, offsets 0..5 hold the bytes of `sta_init`, with offset k taken from bits 8k+7:8k. Every other register reads 0. `host_status`, `irq`, `tx_enable`, `rx_enable`, `soft_reset`, `accept_mode` and `page_sel` are all 0.
- R2: A byte is decoded by its bits 7:5. The value 111 ends any transaction. The value 010 opens a write and 110 opens a read, and both are taken only when no transaction is open. In an opening byte, bit 4 selects the upper half of the register and bits 3:0 give the offset.
- R3: In an open write, the first byte with bits 7:5 = 000 writes its bits 3:0 into the selected half of the latched register, in the same clock edge. The other half of the register is unchanged.
- R4: While a read is open, `host_status[6:3]` shows the selected nibble and the other status bits are 0. When no read is open, `host_status` is 0.
- R5: When no transaction is open, a byte whose opcode is 000, 001, 011, 100 or 101 has no effect. A byte is also ignored whenever `host_valid` is low. In either case no read opens and no register changes.
- R6: Only the first commit byte of a write takes effect. Any further data or address bytes before the next end byte are ignored.
- R7: `page_sel` is 1 exactly when the lower nibble of offset 13 equals 12. While it is 1, offsets 6 and 7 reach a separate pair of registers, and the original offset 6 and 7 contents are kept for page 0.
- R8: The offset 10 bits are transmit-done (bit 0), transmit-fail (bit 1) and receive-done (bit 2). Each is set by its event input. A lower-nibble write of 1 to a bit clears that bit, but an event in the same cycle wins. The upper nibble of offset 10 and its bit 3 read 0 and cannot be written.
- R9: `irq` is 1 exactly when some bit among bits 2:0 of offset 10 is set together with the same bit of offset 11.
- R10: Offset 12 bits 4, 5 and 6 drive `tx_enable`, `rx_enable` and `soft_reset`. Offset 13 bits 5:4 drive `accept_mode`, where 0 is off, 1 is own address only, 2 is own address plus broadcast, and 3 accepts all.
- R11: Offset 15 always reads 0, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | The byte on `host_byte` is presented this cycle |
| host_byte | input | 8 | Command, address or data byte from the host |
| host_status | output | 8 | Read nibble on bits 6:3, other bits zero |
| sta_init | input | 8*STA_BYTES | Reset values for the station-address registers |
| ev_tx_done | input | 1 | Sets interrupt status bit 0 |
| ev_tx_fail | input | 1 | Sets interrupt status bit 1 |
| ev_rx_done | input | 1 | Sets interrupt status bit 2 |
| irq | output | 1 | Masked interrupt request |
| tx_enable | output | 1 | Offset 12 bit 4 |
| rx_enable | output | 1 | Offset 12 bit 5 |
| soft_reset | output | 1 | Offset 12 bit 6 |
| accept_mode | output | 2 | Offset 13 bits 5:4 |
| page_sel | output | 1 | Second page of offsets 6 and 7 is mapped in |

## Verification
The bench writes a distinct nibble, computed from the offset and the half, into each half of every plain register. It then reads both halves of all sixteen offsets. A swapped half, an aliased offset or a lost write each shows up as a mismatch against the arithmetic model. All sixteen nibble values are also written to one register, which exposes a stuck or shorted data bit. Stray opcodes, unstrobed bytes and extra commit bytes are sent with a known value already in place, to tell ignored bytes from bytes that take effect. Event pulses, write-one-clear writes and a clear in the same cycle as an event are combined against chosen mask values, which separates the set/clear priority from the masking.

// File: rtl/nib_pkg.sv
package nib_pkg;

  // Opcode values carried in bits 7:5 of each host byte.
  localparam logic [2:0] CMD_END  = 3'b111;
  localparam logic [2:0] CMD_WADR = 3'b010;
  localparam logic [2:0] CMD_RADR = 3'b110;
  localparam logic [2:0] CMD_DATA = 3'b000;

  typedef enum logic [1:0] {PH_IDLE, PH_WADR, PH_WDONE, PH_READ} phase_e;

  localparam logic [3:0] OFF_PROM_CMD = 4'd6;
  localparam logic [3:0] OFF_PROM_DAT = 4'd7;
  localparam logic [3:0] OFF_ISR      = 4'd10;
  localparam logic [3:0] OFF_IMR      = 4'd11;
  localparam logic [3:0] OFF_CMD1     = 4'd12;
  localparam logic [3:0] OFF_CMD2     = 4'd13;
  localparam logic [3:0] PAGE1_KEY    = 4'hC;
  localparam int         NUM_EVT      = 3;

  function automatic logic [2:0] cmd_field(input logic [7:0] b);
    return b[7:5];
  endfunction

  function automatic logic [7:0] status_lanes(input logic [3:0] n);
    return {1'b0, n, 3'b000};
  endfunction

  function automatic logic [7:0] nib_merge(input logic [7:0] old, input logic hi,
                                           input logic [3:0] n);
    return hi ? {n, old[3:0]} : {old[7:4], n};
  endfunction

endpackage

// File: rtl/nib_cmd_decode.sv
module nib_cmd_decode
  import nib_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [7:0]       byte_in,
  output phase_e           phase,
  output logic [OFF_W-1:0] off,
  output logic             hi,
  output logic             commit,
  output logic [3:0]       nib
);

  phase_e           ph_q;
  logic [OFF_W-1:0] off_q;
  logic             hi_q;
  logic [2:0]       cmd;

  assign cmd = cmd_field(byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      off_q <= '0;
      hi_q  <= 1'b0;
    end else if (valid) begin
      if (cmd == CMD_END) begin
        ph_q <= PH_IDLE;
      end else if (ph_q == PH_IDLE && (cmd == CMD_WADR || cmd == CMD_RADR)) begin
        off_q <= byte_in[OFF_W-1:0];
        hi_q  <= byte_in[4];
        ph_q  <= (cmd == CMD_WADR) ? PH_WADR : PH_READ;
      end else if (ph_q == PH_WADR && cmd == CMD_DATA) begin
        ph_q <= PH_WDONE;
      end
    end
  end

  assign phase  = ph_q;
  assign off    = off_q;
  assign hi     = hi_q;
  assign commit = valid && (ph_q == PH_WADR) && (cmd == CMD_DATA);
  assign nib    = byte_in[3:0];

endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
  import nib_pkg::*;
#(
  parameter int OFF_W     = 4,
  parameter int STA_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [8*STA_BYTES-1:0] sta_init,
  input  logic                   we,
  input  logic [OFF_W-1:0]       w_off,
  input  logic                   w_hi,
  input  logic [3:0]             w_nib,
  input  logic [OFF_W-1:0]       r_off,
  input  logic                   r_hi,
  input  logic [NUM_EVT-1:0]     evt,
  output logic [3:0]             r_nib,
  output logic                   page1,
  output logic [2:0]             cmd1_bits,
  output logic [1:0]             mode_bits,
  output logic [NUM_EVT-1:0]     isr_bits,
  output logic [NUM_EVT-1:0]     imr_bits
);

  localparam int NREG = 1 << OFF_W;

  logic [7:0] rf [NREG];
  logic [7:0] p1 [2];
  logic [7:0] rbyte;

  assign page1 = (rf[OFF_CMD2][3:0] == PAGE1_KEY);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == NREG - 1) begin : g_zero
      assign rf[i] = 8'h00;
    end else if (i == OFF_ISR) begin : g_isr
      logic [7:0] q;
      logic [7:0] clr;
      assign clr = (we && w_off == OFF_W'(i) && !w_hi) ?
                   {{(8-NUM_EVT){1'b0}}, w_nib[NUM_EVT-1:0]} : 8'h00;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 8'h00;
        else        q <= (q & ~clr) | {{(8-NUM_EVT){1'b0}}, evt};
      end
      assign rf[i] = q;
    end else begin : g_store
      logic [7:0] q;
      logic       hit;
      assign hit = we && (w_off == OFF_W'(i)) &&
                   !(page1 && (i == OFF_PROM_CMD || i == OFF_PROM_DAT));
      if (i < STA_BYTES) begin : g_sta
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   q <= sta_init[8*i +: 8];
          else if (hit) q <= nib_merge(q, w_hi, w_nib);
        end
      end else begin : g_plain
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   q <= 8'h00;
          else if (hit) q <= nib_merge(q, w_hi, w_nib);
        end
      end
      assign rf[i] = q;
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_page1
    logic [7:0] q;
    logic       hit;
    assign hit = we && page1 && (w_off == OFF_W'(OFF_PROM_CMD + 4'(j)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 8'h00;
      else if (hit) q <= nib_merge(q, w_hi, w_nib);
    end
    assign p1[j] = q;
  end

  always_comb begin
    rbyte = rf[r_off];
    if (page1 && (r_off == OFF_W'(OFF_PROM_CMD) || r_off == OFF_W'(OFF_PROM_DAT)))
      rbyte = p1[r_off[0]];
    r_nib = r_hi ? rbyte[7:4] : rbyte[3:0];
  end

  assign cmd1_bits = rf[OFF_CMD1][6:4];
  assign mode_bits = rf[OFF_CMD2][5:4];
  assign isr_bits  = rf[OFF_ISR][NUM_EVT-1:0];
  assign imr_bits  = rf[OFF_IMR][NUM_EVT-1:0];

endmodule

// File: rtl/nib_reg_slave.sv
module nib_reg_slave
  import nib_pkg::*;
#(
  parameter int STA_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_valid,
  input  logic [7:0]             host_byte,
  output logic [7:0]             host_status,
  input  logic [8*STA_BYTES-1:0] sta_init,
  input  logic                   ev_tx_done,
  input  logic                   ev_tx_fail,
  input  logic                   ev_rx_done,
  output logic                   irq,
  output logic                   tx_enable,
  output logic                   rx_enable,
  output logic                   soft_reset,
  output logic [1:0]             accept_mode,
  output logic                   page_sel
);

  localparam int OFF_W = 4;

  phase_e             phase;
  logic [OFF_W-1:0]   sel_off;
  logic               sel_hi;
  logic               wr_commit;
  logic [3:0]         wr_nib;
  logic [3:0]         rd_nib;
  logic [2:0]         cmd1_bits;
  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] isr_bits;
  logic [NUM_EVT-1:0] imr_bits;
  logic               st_idle;
  logic               rd_active;

  assign evt_vec = {ev_rx_done, ev_tx_fail, ev_tx_done};

  nib_cmd_decode #(.OFF_W(OFF_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .valid(host_valid), .byte_in(host_byte),
    .phase(phase), .off(sel_off), .hi(sel_hi), .commit(wr_commit), .nib(wr_nib)
  );

  nib_regfile #(.OFF_W(OFF_W), .STA_BYTES(STA_BYTES)) u_rf (
    .clk(clk), .rst_n(rst_n), .sta_init(sta_init),
    .we(wr_commit), .w_off(sel_off), .w_hi(sel_hi), .w_nib(wr_nib),
    .r_off(sel_off), .r_hi(sel_hi), .evt(evt_vec),
    .r_nib(rd_nib), .page1(page_sel), .cmd1_bits(cmd1_bits),
    .mode_bits(accept_mode), .isr_bits(isr_bits), .imr_bits(imr_bits)
  );

  assign st_idle     = (phase == PH_IDLE);
  assign rd_active   = (phase == PH_READ);
  assign host_status = status_lanes(rd_active ? rd_nib : 4'h0);
  assign irq         = |(isr_bits & imr_bits);
  assign tx_enable   = cmd1_bits[0];
  assign rx_enable   = cmd1_bits[1];
  assign soft_reset  = cmd1_bits[2];

endmodule

// File: rtl/nib_reg_slave_chk.sv
module nib_reg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_valid,
  input logic [7:0] host_byte,
  input logic [7:0] host_status,
  input logic       irq,
  input logic       st_idle,
  input logic       rd_active,
  input logic       wr_commit,
  input logic [2:0] isr_bits,
  input logic [2:0] imr_bits,
  input logic [2:0] evt
);

  assert_status_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_status[7] == 1'b0 && host_status[2:0] == 3'b000);

  assert_status_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |-> host_status == 8'h00);

  assert_read_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && st_idle && host_byte[7:5] == 3'b110) |=> rd_active);

  assert_commit_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (host_valid && host_byte[7:5] == 3'b000 && !st_idle));

  assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  assert_stray_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && (!host_valid ||
      (host_byte[7:5] != 3'b010 && host_byte[7:5] != 3'b110))) |=> st_idle);

  assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> (|isr_bits));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|imr_bits) && (|isr_bits)));

endmodule

bind nib_reg_slave nib_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_byte(host_byte),
  .host_status(host_status), .irq(irq), .st_idle(st_idle), .rd_active(rd_active),
  .wr_commit(wr_commit), .isr_bits(isr_bits), .imr_bits(imr_bits), .evt(evt_vec)
);

// File: tb/nib_reg_slave_test.sv
module nib_reg_slave_test;

  localparam logic [47:0] STA = 48'hA1B2C3D4E5F6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0;
  logic [7:0] host_byte = 8'h00;
  logic [7:0] host_status;
  logic       ev_tx_done = 1'b0, ev_tx_fail = 1'b0, ev_rx_done = 1'b0;
  logic       irq, tx_enable, rx_enable, soft_reset, page_sel;
  logic [1:0] accept_mode;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] m0 [16];
  logic [7:0] m1 [2];

  always #5 clk = ~clk;

  nib_reg_slave #(.STA_BYTES(6)) uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_byte(host_byte),
    .host_status(host_status), .sta_init(STA), .ev_tx_done(ev_tx_done),
    .ev_tx_fail(ev_tx_fail), .ev_rx_done(ev_rx_done), .irq(irq),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .soft_reset(soft_reset),
    .accept_mode(accept_mode), .page_sel(page_sel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic mpage();
    return m0[13][3:0] == 4'd12;
  endfunction

  function automatic logic [3:0] mread(input logic [3:0] off, input logic hi);
    logic [7:0] b;
    if (off == 4'd15) b = 8'h00;
    else if (mpage() && (off == 4'd6 || off == 4'd7)) b = m1[off[0]];
    else b = m0[off];
    return hi ? b[7:4] : b[3:0];
  endfunction

  task automatic mwrite(input logic [3:0] off, input logic hi, input logic [3:0] n,
                        input logic [2:0] ev);
    if (off == 4'd10) begin
      if (!hi) m0[10][2:0] = m0[10][2:0] & ~n[2:0];
    end else if (off != 4'd15) begin
      if (mpage() && (off == 4'd6 || off == 4'd7)) begin
        if (hi) m1[off[0]][7:4] = n; else m1[off[0]][3:0] = n;
      end else begin
        if (hi) m0[off][7:4] = n; else m0[off][3:0] = n;
      end
    end
    m0[10][2:0] = m0[10][2:0] | ev;
  endtask

  task automatic send_ev(input logic [7:0] b, input logic [2:0] ev);
    @(negedge clk);
    host_byte = b; host_valid = 1'b1;
    {ev_rx_done, ev_tx_fail, ev_tx_done} = ev;
    @(negedge clk);
    host_valid = 1'b0;
    {ev_rx_done, ev_tx_fail, ev_tx_done} = 3'b000;
  endtask

  task automatic send(input logic [7:0] b);
    send_ev(b, 3'b000);
  endtask

  // Write protocol; optional event pulse aligned with the commit byte.
  task automatic wr(input logic [3:0] off, input logic hi, input logic [3:0] n,
                    input logic [2:0] ev);
    send({4'hE, off});
    send({3'b010, hi, off});
    send({3'b010, hi, off});
    send({3'b010, hi, n});
    send_ev({3'b000, hi, n}, ev);
    mwrite(off, hi, n, ev);
    send({3'b000, hi, n});
    send({4'hE, n});
  endtask

  task automatic rd(input string req, input logic [3:0] off, input logic hi);
    send({4'hE, off});
    send({3'b110, hi, off});
    chk(req, host_status, {1'b0, mread(off, hi), 3'b000});
    send({4'hE, off});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) m0[k] = 8'h00;
    for (int k = 0; k < 6; k++) m0[k] = STA[8*k +: 8];
    m1[0] = 8'h00; m1[1] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state at the ports and in every register half
    chk("R1 status", host_status, 8'h00);
    chk("R1 outputs", {irq, tx_enable, rx_enable, soft_reset, accept_mode, page_sel}, 8'h00);
    for (int o = 0; o < 16; o++)
      for (int h = 0; h < 2; h++) rd("R1 reset value", 4'(o), h[0]);

    // R2: a write-address byte does not open a read
    send(8'hE3); send(8'h43);
    chk("R2 write phase shows no data", host_status, 8'h00);
    send(8'hE3);
    chk("R4 status after end", host_status, 8'h00);

    // R3: sweep over both halves of every plain register
    for (int o = 0; o < 15; o++)
      if (o != 10 && o != 13)
        for (int h = 0; h < 2; h++) wr(4'(o), h[0], 4'((o * 3 + h * 7 + 5) & 15), 3'b000);
    for (int o = 0; o < 16; o++)
      for (int h = 0; h < 2; h++) rd("R3 sweep readback", 4'(o), h[0]);
    for (int v = 0; v < 16; v++) begin
      wr(4'd14, 1'b1, 4'(v), 3'b000);
      rd("R3 all nibble values", 4'd14, 1'b1);
      rd("R3 other half kept", 4'd14, 1'b0);
    end

    // R11: offset 15 discards writes
    wr(4'd15, 1'b0, 4'hA, 3'b000);
    rd("R11 offset 15 reads zero", 4'd15, 1'b0);

    // R5: stray opcodes and unstrobed bytes in idle
    send(8'h2A); send(8'h8A); send(8'h05); send(8'hA5); send(8'h3E);
    chk("R5 stray opcodes open nothing", host_status, 8'h00);
    rd("R5 stray opcodes leave registers", 4'd5, 1'b0);
    rd("R5 stray opcodes leave registers", 4'd14, 1'b0);
    @(negedge clk); host_byte = 8'hC2; host_valid = 1'b0;
    @(negedge clk);
    chk("R5 unstrobed read byte ignored", host_status, 8'h00);

    // R6: extra data and address bytes after the commit are ignored
    send(8'hE3); send(8'h43); send(8'h43); send(8'h49);
    send(8'h09); mwrite(4'd3, 1'b0, 4'h9, 3'b000);
    send(8'h07); send(8'h46); send(8'h0C);
    send(8'hE0);
    rd("R6 only first commit lands", 4'd3, 1'b0);

    // R10: unit enables and accept mode
    wr(4'd12, 1'b1, 4'h7, 3'b000);
    chk("R10 enables all set", {5'b0, soft_reset, rx_enable, tx_enable}, 8'h07);
    wr(4'd12, 1'b1, 4'h2, 3'b000);
    chk("R10 receive enable only", {5'b0, soft_reset, rx_enable, tx_enable}, 8'h02);
    wr(4'd13, 1'b1, 4'h3, 3'b000);
    chk("R10 accept all", {6'b0, accept_mode}, 8'h03);
    wr(4'd13, 1'b1, 4'hE, 3'b000);
    chk("R10 accept broadcast", {6'b0, accept_mode}, 8'h02);

    // R7: page switch maps offsets 6 and 7 elsewhere
    wr(4'd13, 1'b0, 4'hC, 3'b000);
    chk("R7 page selected", {7'b0, page_sel}, 8'h01);
    wr(4'd6, 1'b0, 4'h9, 3'b000);
    wr(4'd7, 1'b1, 4'h4, 3'b000);
    rd("R7 page1 offset 6", 4'd6, 1'b0);
    rd("R7 page1 offset 7", 4'd7, 1'b1);
    rd("R7 other offsets unchanged", 4'd8, 1'b0);
    wr(4'd13, 1'b0, 4'hB, 3'b000);
    chk("R7 page cleared", {7'b0, page_sel}, 8'h00);
    rd("R7 page0 offset 6 kept", 4'd6, 1'b0);
    rd("R7 page0 offset 7 kept", 4'd7, 1'b1);

    // R8 and R9: interrupt status and mask
    wr(4'd11, 1'b0, 4'h5, 3'b000);
    send_ev(8'hE0, 3'b010); m0[10][1] = 1'b1;
    rd("R8 fail event sets bit 1", 4'd10, 1'b0);
    chk("R9 unmasked bit gives no irq", {7'b0, irq}, 8'h00);
    send_ev(8'hE0, 3'b001); m0[10][0] = 1'b1;
    chk("R9 masked bit raises irq", {7'b0, irq}, 8'h01);
    wr(4'd10, 1'b0, 4'h1, 3'b000);
    rd("R8 write one clears", 4'd10, 1'b0);
    chk("R9 irq drops", {7'b0, irq}, 8'h00);
    wr(4'd10, 1'b0, 4'h6, 3'b100);
    rd("R8 event wins over clear", 4'd10, 1'b0);
    chk("R9 receive bit raises irq", {7'b0, irq}, 8'h01);
    wr(4'd10, 1'b1, 4'hF, 3'b000);
    rd("R8 upper nibble reads zero", 4'd10, 1'b1);
    wr(4'd10, 1'b0, 4'hF, 3'b000);
    rd("R8 all cleared", 4'd10, 1'b0);
    chk("R9 irq idle", {7'b0, irq}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule